// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a 10-bit successive-approximation analog-to-digital converter. It divides the system clock down to a slower converter clock and runs each conversion against that clock. It fires a one-cycle sample-and-hold strobe at the sampling point and then resolves the result one bit per converter-clock cycle, from MSB to LSB. To do this it presents a trial code to the DAC and reads back a single comparator bit. When the conversion ends it writes the result and raises a sticky completion flag.

Starting the block: software raises `enable`, selects a clock ratio and pulses `start_set`. The first conversion after enable is a longer warm-up conversion. After that, conversions use the normal length. In free-running mode the pending start stays set, so each conversion is followed directly by the next. When the differential path is selected, a conversion may begin only on alternate converter-clock edges. A result that finishes shortly after the differential flag or the reference selection changed is marked suspect.

Top module: `adc_conv_sequencer`

## Requirements
- R1: The converter clock period is 2^(presc_sel+1) system clocks for presc_sel 0..6, and 128 for code 7. After each converter rising edge, conv_clk is high for the first half of the period. The divider is held at zero while enable is low and starts counting on the first clock edge with enable high.
- R2: A start_set pulse is registered as a pending start, and the conversion begins on the next converter rising edge. A start_set pulse given while enable is low has no effect.
- R3: While diff_sel is 1, a conversion may begin only on odd-numbered converter rising edges, counting the first edge after enable as number 1.
- R4: The first conversion after enable lasts 25 converter-clock cycles. Every later conversion lasts 13 cycles. done rises on the converter rising edge that ends the conversion.
- R5: sample_strobe is a single system-clock pulse on the converter falling edge that lies 1.5 cycles after the start of a normal conversion, or 13.5 cycles after the start of the warm-up conversion. There is exactly one strobe per conversion.
- R6: dac_code carries the trial code. cmp_in = 1 means the analog input is at or above dac_code. The written result equals the input code for every code from 0 to 1023, and result changes only when done is set.
- R7: done stays set until done_clr is 1 at a clock edge. If done_clr arrives on the same edge as a completion, done stays set.
- R8: In single mode, start_pending drops on the edge that completes the conversion. In free-running mode it stays high, and the next conversion starts on that same edge, subject to R3.
- R9: suspect is written at each completion. It is 1 when diff_sel or ref_sel changed within the last SETTLE_CYCLES system clocks, and 0 otherwise.
- R10: Lowering enable aborts any conversion, clears busy and start_pending, keeps done and result, and makes the next conversion a warm-up conversion.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; low holds the divider and aborts conversions |
| start_set | input | 1 | Start request pulse |
| free_run | input | 1 | 1 selects free-running conversions |
| diff_sel | input | 1 | Differential channel selected |
| ref_sel | input | 2 | Reference selection; watched for changes |
| presc_sel | input | 3 | Divider code |
| cmp_in | input | 1 | Comparator: input at or above dac_code |
| done_clr | input | 1 | Write-one-to-clear for done |
| conv_clk | output | 1 | Converter clock |
| busy | output | 1 | Conversion in progress |
| start_pending | output | 1 | Start request held |
| sample_strobe | output | 1 | Sample-and-hold pulse |
| dac_code | output | 10 | Trial code for the DAC |
| result | output | 10 | Last conversion result |
| done | output | 1 | Sticky completion flag |
| suspect | output | 1 | Last result fell within the settling window |

## Verification
Two events can land on the same system-clock edge. The first is a completion, which sets done, together with a clear from software. The second is the end of one free-running conversion together with the start of the next. The bench provokes both in free-running mode by driving done_clr into exactly the edge that ends the second conversion. It judges the result by checking three things: done is still high after that edge, done falls one edge later, and start_pending never dropped. In the differential case, the restart moves to the following odd converter edge, and the bench checks the shifted completion edge arithmetically.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;

    typedef enum logic {
        CONV_NORMAL   = 1'b0,
        CONV_EXTENDED = 1'b1
    } conv_kind_e;

    // Divider exponent for a select code, limited to the widest ratio.
    function automatic int unsigned clamp_log2(input int unsigned code,
                                               input int unsigned max_log2);
        return (code + 1 > max_log2) ? max_log2 : code + 1;
    endfunction

endpackage

// File: rtl/adcseq_prescaler.sv
`timescale 1ns/1ps
module adcseq_prescaler #(
    parameter int SEL_W    = 3,
    parameter int MAX_LOG2 = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    output logic             rise,
    output logic             fall,
    output logic             odd_rise,
    output logic             conv_clk
);
    import adcseq_pkg::*;

    localparam int CW = MAX_LOG2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          par;
    } div_state_t;

    div_state_t   div_d, div_q;
    logic [CW-1:0] last_cnt;
    logic [CW-1:0] half_cnt;
    int unsigned   lg;

    always_comb begin
        lg       = clamp_log2(32'(sel), MAX_LOG2);
        last_cnt = CW'((32'd1 << lg) - 32'd1);
        half_cnt = last_cnt >> 1;
        rise     = enable && (div_q.cnt == last_cnt);
        fall     = enable && (div_q.cnt == half_cnt);
        odd_rise = rise && !div_q.par;
        conv_clk = enable && (div_q.cnt <= half_cnt);

        div_d = div_q;
        if (!enable) begin
            div_d = '0;
        end else begin
            div_d.cnt = rise ? '0 : div_q.cnt + CW'(1);
            if (rise) begin
                div_d.par = ~div_q.par;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/adcseq_sar.sv
`timescale 1ns/1ps
module adcseq_sar #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             step,
    input  logic             cmp_in,
    output logic [RES_W-1:0] code
);
    typedef struct packed {
        logic [RES_W-1:0] code;
        logic [RES_W-1:0] ptr;
    } sar_state_t;

    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    sar_state_t sar_d, sar_q;

    always_comb begin
        sar_d = sar_q;
        if (clear) begin
            sar_d = '0;
        end else if (load) begin
            sar_d.code = TOP_BIT;
            sar_d.ptr  = TOP_BIT;
        end else if (step) begin
            sar_d.ptr  = sar_q.ptr >> 1;
            sar_d.code = (cmp_in ? sar_q.code : (sar_q.code & ~sar_q.ptr))
                         | (sar_q.ptr >> 1);
        end
        code = sar_q.code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q <= '0;
        end else begin
            sar_q <= sar_d;
        end
    end

endmodule

// File: rtl/adcseq_settle.sv
`timescale 1ns/1ps
module adcseq_settle #(
    parameter int SETTLE_CYCLES = 6250,
    parameter int REF_W         = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             diff_sel,
    input  logic [REF_W-1:0] ref_sel,
    output logic             active
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             prev_diff;
        logic [REF_W-1:0] prev_ref;
    } settle_state_t;

    settle_state_t st_d, st_q;
    logic          changed;

    always_comb begin
        changed        = (diff_sel != st_q.prev_diff) || (ref_sel != st_q.prev_ref);
        st_d           = st_q;
        st_d.prev_diff = diff_sel;
        st_d.prev_ref  = ref_sel;
        if (changed) begin
            st_d.cnt = CNT_W'(SETTLE_CYCLES);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        active = (st_q.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/adc_conv_sequencer.sv
`timescale 1ns/1ps
module adc_conv_sequencer #(
    parameter int RES_W         = 10,
    parameter int SEL_W         = 3,
    parameter int MAX_LOG2      = 7,
    parameter int REF_W         = 2,
    parameter int NORM_LEN      = 13,
    parameter int EXT_LEN       = 25,
    parameter int NORM_SH       = 1,
    parameter int EXT_SH        = 13,
    parameter int SETTLE_CYCLES = 6250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start_set,
    input  logic             free_run,
    input  logic             diff_sel,
    input  logic [REF_W-1:0] ref_sel,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic             cmp_in,
    input  logic             done_clr,
    output logic             conv_clk,
    output logic             busy,
    output logic             start_pending,
    output logic             sample_strobe,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             done,
    output logic             suspect
);
    import adcseq_pkg::*;

    localparam int CYC_W = $clog2(EXT_LEN + 1);

    typedef struct packed {
        logic             busy;
        conv_kind_e       kind;
        logic             first;
        logic             req;
        logic [CYC_W-1:0] cyc;
        logic             strobe;
        logic             done;
        logic             suspect;
        logic [RES_W-1:0] result;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic             rise, fall, odd_rise;
    logic             settle_active;
    logic [RES_W-1:0] sar_code;
    logic [CYC_W-1:0] sh_point, len_last;
    logic             complete, start_ok, req_keep;
    logic             sar_clear, sar_load, sar_step;

    adcseq_prescaler #(.SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .sel      (presc_sel),
        .rise     (rise),
        .fall     (fall),
        .odd_rise (odd_rise),
        .conv_clk (conv_clk)
    );

    adcseq_sar #(.RES_W(RES_W)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (sar_clear),
        .load   (sar_load),
        .step   (sar_step),
        .cmp_in (cmp_in),
        .code   (sar_code)
    );

    adcseq_settle #(.SETTLE_CYCLES(SETTLE_CYCLES), .REF_W(REF_W)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .diff_sel (diff_sel),
        .ref_sel  (ref_sel),
        .active   (settle_active)
    );

    always_comb begin
        sh_point = (s_q.kind == CONV_EXTENDED) ? CYC_W'(EXT_SH) : CYC_W'(NORM_SH);
        len_last = (s_q.kind == CONV_EXTENDED) ? CYC_W'(EXT_LEN - 1) : CYC_W'(NORM_LEN - 1);

        complete = rise && s_q.busy && (s_q.cyc == len_last);
        sar_load = fall && s_q.busy && (s_q.cyc == sh_point);
        sar_step = rise && s_q.busy && (s_q.cyc >= sh_point)
                   && (s_q.cyc < sh_point + CYC_W'(RES_W));

        // Single mode consumes the request at completion; free-run keeps it.
        req_keep  = s_q.req && !(complete && !free_run);
        start_ok  = rise && req_keep && (!s_q.busy || complete)
                    && (!diff_sel || odd_rise);
        sar_clear = !enable || complete || start_ok;

        s_d        = s_q;
        s_d.strobe = sar_load;

        if (s_q.busy && rise) begin
            s_d.cyc = s_q.cyc + CYC_W'(1);
        end

        if (complete) begin
            s_d.busy    = 1'b0;
            s_d.done    = 1'b1;
            s_d.result  = sar_code;
            s_d.suspect = settle_active;
        end else if (done_clr) begin
            s_d.done = 1'b0;
        end

        s_d.req = req_keep || start_set;

        if (start_ok) begin
            s_d.busy  = 1'b1;
            s_d.cyc   = '0;
            s_d.kind  = s_q.first ? CONV_EXTENDED : CONV_NORMAL;
            s_d.first = 1'b0;
        end

        if (!enable) begin
            s_d.busy   = 1'b0;
            s_d.req    = 1'b0;
            s_d.first  = 1'b1;
            s_d.cyc    = '0;
            s_d.strobe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.first <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy          = s_q.busy;
    assign start_pending = s_q.req;
    assign sample_strobe = s_q.strobe;
    assign dac_code      = sar_code;
    assign result        = s_q.result;
    assign done          = s_q.done;
    assign suspect       = s_q.suspect;

endmodule

// File: rtl/adcseq_checker.sv
`timescale 1ns/1ps
module adcseq_checker #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             start_set,
    input logic             free_run,
    input logic             done_clr,
    input logic             busy,
    input logic             start_pending,
    input logic             sample_strobe,
    input logic [RES_W-1:0] result,
    input logic             done
);

    p_strobe_in_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> busy);

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> !sample_strobe);

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done);

    p_done_from_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !start_pending));

    p_single_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(free_run) && !$past(start_set)) |-> !start_pending);

    p_result_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

endmodule

bind adc_conv_sequencer adcseq_checker #(.RES_W(RES_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .start_set     (start_set),
    .free_run      (free_run),
    .done_clr      (done_clr),
    .busy          (busy),
    .start_pending (start_pending),
    .sample_strobe (sample_strobe),
    .result        (result),
    .done          (done)
);

// File: tb/adc_conv_sequencer_bench.sv
`timescale 1ns/1ps
module adc_conv_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, start_set = 1'b0, free_run = 1'b0;
    logic       diff_sel = 1'b0, done_clr = 1'b0;
    logic [1:0] ref_sel = 2'd0;
    logic [2:0] presc_sel = 3'd0;
    logic       cmp_in;
    logic       conv_clk, busy, start_pending, sample_strobe, done, suspect;
    logic [9:0] dac_code, result;
    int         target = 0;
    int         errs = 0;
    int         checks = 0;

    always #10 clk = ~clk;

    // Comparator model: input at or above the trial code.
    assign cmp_in = (10'(target) >= dac_code);

    adc_conv_sequencer u_adc_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_set(start_set),
        .free_run(free_run), .diff_sel(diff_sel), .ref_sel(ref_sel),
        .presc_sel(presc_sel), .cmp_in(cmp_in), .done_clr(done_clr),
        .conv_clk(conv_clk), .busy(busy), .start_pending(start_pending),
        .sample_strobe(sample_strobe), .dac_code(dac_code), .result(result),
        .done(done), .suspect(suspect)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_done();
        done_clr = 1'b1;
        step();
        done_clr = 1'b0;
    endtask

    // Measure one warm-up conversion from the enable edge.
    task automatic timing_run(input int sel, input bit diff, input bit late, input string tag);
        int lg, div, r, exp_done, exp_sh, n, done_at, sh_at, sh_cnt, clk_bad;
        lg = (sel + 1 > 7) ? 7 : sel + 1;
        div = 1 << lg;
        r = !late ? 1 : (diff ? 3 : 2);
        exp_done = div * (r + 25);
        exp_sh = div * r + div * 13 + div / 2;
        enable = 1'b0; free_run = 1'b0; start_set = 1'b0;
        step();
        clear_done();
        presc_sel = 3'(sel); diff_sel = diff;
        enable = 1'b1; start_set = !late;
        step();
        start_set = 1'b0;
        n = 1; done_at = -1; sh_at = -1; sh_cnt = 0; clk_bad = 0;
        while (n < exp_done + 4) begin
            start_set = late && (n == div + 1);
            step();
            n++;
            if (conv_clk !== ((n % div) < (div / 2))) clk_bad++;
            if (sample_strobe) begin sh_cnt++; sh_at = n; end
            if (done && done_at < 0) done_at = n;
        end
        start_set = 1'b0;
        chk({"R1 conv_clk shape ", tag}, clk_bad, 0);
        chk({"R4 warm-up completion edge ", tag}, done_at, exp_done);
        chk({"R5 strobe edge ", tag}, sh_at, exp_sh);
        chk({"R5 strobe count ", tag}, sh_cnt, 1);
        chk({"R8 single pending dropped ", tag}, int'(start_pending), 0);
        if (late && diff) chk({"R3 odd-edge start ", tag}, done_at, div * 28);
        if (late && !diff) chk({"R2 next-edge start ", tag}, done_at, div * 27);
    endtask

    // Free-running run with divider 4; checks clear/completion collision.
    task automatic fr_run(input bit diff, input int exp1, input int exp2, input int exp3);
        int n;
        enable = 1'b0; start_set = 1'b0;
        step();
        clear_done();
        presc_sel = 3'd1; diff_sel = diff; free_run = 1'b1;
        enable = 1'b1; start_set = 1'b1;
        step();
        start_set = 1'b0;
        n = 1;
        while (n < exp3 + 2) begin
            done_clr = (n == exp1) || (n == exp2 - 1) || (n == exp2);
            if (n == exp2) free_run = 1'b0;
            step();
            n++;
            if (n == exp1) chk("R4 free-run first completion", int'(done), 1);
            if (n == exp1 + 1) chk("R7 clear drops done", int'(done), 0);
            if (n == exp2 - 1) chk("R8 no early restart completion", int'(done), 0);
            if (n == exp2) begin
                chk("R7 set wins over clear", int'(done), 1);
                chk("R8 free-run keeps pending", int'(start_pending), 1);
                if (diff) chk("R3 free-run restart on odd edge", int'(done), 1);
            end
            if (n == exp2 + 1) chk("R7 clear after collision", int'(done), 0);
            if (n == exp3 - 1) chk("R4 normal length not early", int'(done), 0);
            if (n == exp3) begin
                chk("R4 normal length completion", int'(done), 1);
                chk("R8 single drops pending", int'(start_pending), 0);
                chk("R8 idle after single", int'(busy), 0);
            end
        end
        done_clr = 1'b0;
        free_run = 1'b0;
    endtask

    task automatic convert_once(output int res, output int sus);
        int k;
        start_set = 1'b1;
        step();
        start_set = 1'b0;
        k = 0;
        while (!done && k < 600) begin step(); k++; end
        res = int'(result);
        sus = int'(suspect);
        clear_done();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog R4: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        int res, sus, bad, sus_bad, n, seen;
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R11 reset state
        chk("R11 conv_clk", int'(conv_clk), 0);
        chk("R11 busy", int'(busy), 0);
        chk("R11 pending", int'(start_pending), 0);
        chk("R11 strobe", int'(sample_strobe), 0);
        chk("R11 dac_code", int'(dac_code), 0);
        chk("R11 result", int'(result), 0);
        chk("R11 done", int'(done), 0);
        chk("R11 suspect", int'(suspect), 0);

        // R2: start while disabled is ignored
        enable = 1'b0; start_set = 1'b1;
        step();
        start_set = 1'b0; enable = 1'b1;
        seen = 0;
        for (int i = 0; i < 80; i++) begin
            step();
            if (busy || done || start_pending) seen++;
        end
        chk("R2 start ignored while disabled", seen, 0);

        // R1, R4, R5 over every divider code
        for (int s = 0; s < 8; s++) timing_run(s, 1'b0, 1'b0, $sformatf("sel%0d", s));
        timing_run(2, 1'b0, 1'b1, "late single-ended");
        timing_run(2, 1'b1, 1'b1, "late differential");
        timing_run(2, 1'b1, 1'b0, "early differential");

        fr_run(1'b0, 104, 156, 208);
        fr_run(1'b1, 104, 160, 216);

        // R10: abort mid-conversion, then warm-up again
        enable = 1'b0; step(); clear_done();
        presc_sel = 3'd0; diff_sel = 1'b0;
        target = 300;
        enable = 1'b1; start_set = 1'b1;
        step();
        start_set = 1'b0;
        repeat (19) step();
        enable = 1'b0;
        step();
        chk("R10 abort clears busy", int'(busy), 0);
        chk("R10 abort clears pending", int'(start_pending), 0);
        chk("R10 abort keeps done low", int'(done), 0);
        enable = 1'b1; start_set = 1'b1;
        step();
        start_set = 1'b0;
        n = 1; seen = -1;
        while (n < 60) begin
            step(); n++;
            if (done && seen < 0) seen = n;
        end
        chk("R10 warm-up re-armed", seen, 52);
        chk("R6 result after abort", int'(result), 300);

        // R6 sweep of every code with fresh reset (no settle activity)
        rst_n = 1'b0; enable = 1'b0; diff_sel = 1'b0; ref_sel = 2'd0; presc_sel = 3'd0;
        step();
        rst_n = 1'b1;
        step();
        enable = 1'b1;
        bad = 0; sus_bad = 0;
        for (int t = 0; t < 1024; t++) begin
            target = t;
            convert_once(res, sus);
            if (res != t) begin
                bad++;
                chk("R6 sweep result", res, t);
            end
            if (sus != 0) sus_bad++;
        end
        chk("R6 sweep mismatches", bad, 0);
        chk("R9 quiet inputs not suspect", sus_bad, 0);

        // R9 settling window
        target = 77;
        ref_sel = 2'd1;
        step();
        convert_once(res, sus);
        chk("R9 suspect after reference change", sus, 1);
        repeat (6300) step();
        convert_once(res, sus);
        chk("R9 clean after window", sus, 0);
        chk("R6 result code 77", res, 77);
        diff_sel = 1'b1;
        step();
        convert_once(res, sus);
        chk("R9 suspect after differential change", sus, 1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule